// File: doc/BRIEF.md
# Reshapeable LUT RAM Element

This block is a single 64-bit storage element. A static shape input sets how the bits are used. In deep shape the element is 64 words of 1 bit. In wide shape it is 32 words of 2 bits. The element has two address inputs. The write address is 8 bits and is used on the rising clock edge, gated by a write enable. The read address is 6 bits and is decoded combinationally onto two outputs.

In wide shape, word k is stored in two places. Bit 0 goes to location k of the lower half of the storage and bit 1 goes to location k of the upper half. The primary output reads the upper half and the secondary output reads the lower half. Because of this layout, data written in one shape can be read back through the other.

The two write-address bits above the read range serve cascading. Several of these elements can be stacked into a deeper memory. A cascade configuration input sets how many of those upper bits must match this slice's fixed identity before a write lands. The storage is cleared by reset.

Top module: `reshape_lut_ram`

## Requirements
- R1: While reset is active, and after it is released but before any write, all 64 storage bits read as 0 on both outputs.
- R2: In deep shape (shape_sel = 0), a qualified write stores wr_data[0] at location wr_addr[5:0] on the rising edge. wr_data[1] has no effect.
- R3: In deep shape, rd_pri shows location rd_addr[5:0] combinationally and rd_sec is 0.
- R4: In wide shape (shape_sel = 1), a qualified write stores wr_data[0] at location wr_addr[4:0] and wr_data[1] at location 32 + wr_addr[4:0]. wr_addr[5] has no effect.
- R5: In wide shape, rd_pri shows location 32 + rd_addr[4:0] and rd_sec shows location rd_addr[4:0]. rd_addr[5] has no effect.
- R6: Both shapes address the same 64 bits. A word written in wide shape at k reads back in deep shape at k (bit 0) and at k + 32 (bit 1).
- R7: With wr_en low, no storage bit changes.
- R8: The write qualification depends on casc_cfg:
  - 2'b00 or 2'b11: wr_addr[7:6] is ignored.
  - 2'b01: a write needs wr_addr[6] equal to bit 0 of SLICE_ID.
  - 2'b10: a write needs wr_addr[7:6] equal to SLICE_ID.
  - SLICE_ID is 0 by default.
- R9: A read of the location being written returns the old value until the clock edge and the new value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| shape_sel | input | 1 | 0 = 64x1 deep shape, 1 = 32x2 wide shape (static) |
| casc_cfg | input | 2 | Cascade qualification on write-address upper bits (static) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 8 | Write address; bits [7:6] feed the cascade qualification |
| wr_data | input | 2 | Write data |
| rd_addr | input | 6 | Read address |
| rd_pri | output | 1 | Primary read data |
| rd_sec | output | 1 | Secondary read data |

## Verification
The assertions assume that shape_sel and casc_cfg are static in use. Where a property compares outputs across a clock edge, it excuses any cycle in which the shape or the read address changed. The stimulus changes every input only at the falling edge. It also changes shape and cascade configuration between operations, so those excused cycles occur but every settled cycle is still compared. Write data in deep shape drives both data bits, so the bench sees when the unused bit leaks into storage.

// File: rtl/lram_pkg.sv
`timescale 1ns/1ps
package lram_pkg;

  typedef enum logic {
    SHAPE_DEEP = 1'b0,
    SHAPE_WIDE = 1'b1
  } shape_e;

  typedef enum logic [1:0] {
    CASC_NONE = 2'b00,
    CASC_PAIR = 2'b01,
    CASC_QUAD = 2'b10,
    CASC_RSVD = 2'b11
  } casc_e;

endpackage

// File: rtl/lram_rst_sync.sv
`timescale 1ns/1ps
module lram_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/lram_wr_dec.sv
`timescale 1ns/1ps
module lram_wr_dec
  import lram_pkg::*;
#(
  parameter int unsigned BITS     = 64,
  parameter int unsigned CASC_W   = 2,
  parameter int unsigned SLICE_ID = 0,
  localparam int unsigned RA_W    = $clog2(BITS),
  localparam int unsigned HA_W    = RA_W - 1,
  localparam int unsigned HALF    = BITS / 2,
  localparam int unsigned WA_W    = RA_W + CASC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  shape_e          shape,
  input  casc_e           casc,
  input  logic            wr_en,
  input  logic [WA_W-1:0] wr_addr,
  input  logic [1:0]      wr_data,
  output logic            wr_hit,
  output logic [BITS-1:0] bit_we,
  output logic [BITS-1:0] bit_wd
);
  localparam logic [CASC_W-1:0] SID = CASC_W'(SLICE_ID);

  logic              qual;
  logic [CASC_W-1:0] upper;

  assign upper = wr_addr[WA_W-1:RA_W];

  always_comb begin
    unique case (casc)
      CASC_PAIR: qual = (upper[0] == SID[0]);
      CASC_QUAD: qual = (upper == SID);
      default:   qual = 1'b1;
    endcase
  end

  assign wr_hit = wr_en & qual;

  for (genvar i = 0; i < BITS; i++) begin : g_bit
    localparam logic [RA_W-1:0] FULL  = RA_W'(i);
    localparam logic [HA_W-1:0] LOC   = HA_W'(i % HALF);
    localparam logic            UPPER = (i >= HALF);
    logic sel_deep;
    logic sel_wide;
    always_comb begin
      sel_deep  = (shape == SHAPE_DEEP) && (wr_addr[RA_W-1:0] == FULL);
      sel_wide  = (shape == SHAPE_WIDE) && (wr_addr[HA_W-1:0] == LOC);
      bit_we[i] = wr_hit && (sel_deep || sel_wide);
      bit_wd[i] = (shape == SHAPE_WIDE && UPPER) ? wr_data[1] : wr_data[0];
    end
  end

  // R2
  deep_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shape == SHAPE_DEEP) |-> ($countones(bit_we) <= 1));

  // R4
  wide_pair_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shape == SHAPE_WIDE && wr_hit) |-> ($countones(bit_we) == 2));

  // R7
  idle_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (bit_we == '0));
endmodule

// File: rtl/lram_store.sv
`timescale 1ns/1ps
module lram_store #(
  parameter int unsigned BITS = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] bit_we,
  input  logic [BITS-1:0] bit_wd,
  output logic [BITS-1:0] bits_q
);
  logic [BITS-1:0] bits_d;

  always_comb begin
    bits_d = bit_wd;
  end

  for (genvar i = 0; i < BITS; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bits_q[i] <= 1'b0;
      else if (bit_we[i]) bits_q[i] <= bits_d[i];
    end
  end
endmodule

// File: rtl/lram_rd_mux.sv
`timescale 1ns/1ps
module lram_rd_mux
  import lram_pkg::*;
#(
  parameter int unsigned BITS = 64,
  localparam int unsigned RA_W = $clog2(BITS),
  localparam int unsigned HA_W = RA_W - 1
) (
  input  shape_e          shape,
  input  logic [RA_W-1:0] rd_addr,
  input  logic [BITS-1:0] bits_q,
  output logic            rd_pri,
  output logic            rd_sec
);
  logic [RA_W-1:0] hi_idx;
  logic [RA_W-1:0] lo_idx;

  always_comb begin
    hi_idx = {1'b1, rd_addr[HA_W-1:0]};
    lo_idx = {1'b0, rd_addr[HA_W-1:0]};
    if (shape == SHAPE_WIDE) begin
      rd_pri = bits_q[hi_idx];
      rd_sec = bits_q[lo_idx];
    end else begin
      rd_pri = bits_q[rd_addr];
      rd_sec = 1'b0;
    end
  end
endmodule

// File: rtl/reshape_lut_ram.sv
`timescale 1ns/1ps
module reshape_lut_ram
  import lram_pkg::*;
#(
  parameter int unsigned BITS     = 64,
  parameter int unsigned CASC_W   = 2,
  parameter int unsigned SLICE_ID = 0,
  localparam int unsigned RA_W    = $clog2(BITS),
  localparam int unsigned HA_W    = RA_W - 1,
  localparam int unsigned WA_W    = RA_W + CASC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shape_sel,
  input  logic [1:0]      casc_cfg,
  input  logic            wr_en,
  input  logic [WA_W-1:0] wr_addr,
  input  logic [1:0]      wr_data,
  input  logic [RA_W-1:0] rd_addr,
  output logic            rd_pri,
  output logic            rd_sec
);
  shape_e          shape;
  casc_e           casc;
  logic            rst_ok;
  logic            wr_hit;
  logic [BITS-1:0] bit_we;
  logic [BITS-1:0] bit_wd;
  logic [BITS-1:0] bits_q;

  assign shape = shape_e'(shape_sel);
  assign casc  = casc_e'(casc_cfg);

  lram_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ok)
  );

  lram_wr_dec #(.BITS(BITS), .CASC_W(CASC_W), .SLICE_ID(SLICE_ID)) u_dec (
    .clk(clk), .rst_n(rst_ok), .shape(shape), .casc(casc),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_hit(wr_hit), .bit_we(bit_we), .bit_wd(bit_wd)
  );

  lram_store #(.BITS(BITS)) u_store (
    .clk(clk), .rst_n(rst_ok), .bit_we(bit_we), .bit_wd(bit_wd), .bits_q(bits_q)
  );

  lram_rd_mux #(.BITS(BITS)) u_rd (
    .shape(shape), .rd_addr(rd_addr), .bits_q(bits_q),
    .rd_pri(rd_pri), .rd_sec(rd_sec)
  );

  // R3
  deep_sec_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (shape == SHAPE_DEEP) |-> (rd_sec == 1'b0));

  // R7
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !wr_hit |=> (!$stable(rd_addr) || !$stable(shape_sel) ||
                 ($stable(rd_pri) && $stable(rd_sec))));

  // R2
  deep_write_read_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_hit && shape == SHAPE_DEEP) |=>
      (shape != SHAPE_DEEP || rd_addr != $past(wr_addr[RA_W-1:0]) ||
       rd_pri == $past(wr_data[0])));

  // R4
  wide_write_read_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_hit && shape == SHAPE_WIDE) |=>
      (shape != SHAPE_WIDE || rd_addr[HA_W-1:0] != $past(wr_addr[HA_W-1:0]) ||
       (rd_pri == $past(wr_data[1]) && rd_sec == $past(wr_data[0]))));
endmodule

// File: tb/tb_reshape_lut_ram.sv
`timescale 1ns/1ps
module tb_reshape_lut_ram;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       shape_sel;
  logic [1:0] casc_cfg;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [1:0] wr_data;
  logic [5:0] rd_addr;
  logic       rd_pri;
  logic       rd_sec;

  int n_chk  = 0;
  int n_fail = 0;
  logic [63:0] model;

  always #2 clk = ~clk;

  reshape_lut_ram dut (
    .clk(clk), .rst_n(rst_n), .shape_sel(shape_sel), .casc_cfg(casc_cfg),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_pri(rd_pri), .rd_sec(rd_sec)
  );

  function automatic logic exp_pri();
    if (shape_sel) return model[32 + int'(rd_addr[4:0])];
    return model[int'(rd_addr)];
  endfunction

  function automatic logic exp_sec();
    if (shape_sel) return model[int'(rd_addr[4:0])];
    return 1'b0;
  endfunction

  function automatic bit qualifies();
    if (casc_cfg == 2'b01) return wr_addr[6] == 1'b0;
    if (casc_cfg == 2'b10) return wr_addr[7:6] == 2'b00;
    return 1'b1;
  endfunction

  task automatic check(string tag);
    logic ep, es;
    ep = exp_pri();
    es = exp_sec();
    n_chk++;
    if (rd_pri !== ep) begin
      n_fail++;
      $display("FAIL %s rd_pri actual=%b expected=%b ra=%0d t=%0t", tag, rd_pri, ep, rd_addr, $time);
    end
    n_chk++;
    if (rd_sec !== es) begin
      n_fail++;
      $display("FAIL %s rd_sec actual=%b expected=%b ra=%0d t=%0t", tag, rd_sec, es, rd_addr, $time);
    end
  endtask

  // One operation: inputs set at the falling edge, outputs checked before and after the rising edge
  task automatic op(input logic sh, input logic [1:0] cc, input logic we,
                    input logic [7:0] wa, input logic [1:0] wd,
                    input logic [5:0] ra, input string tag);
    @(negedge clk);
    shape_sel = sh; casc_cfg = cc; wr_en = we;
    wr_addr = wa; wr_data = wd; rd_addr = ra;
    #1 check({tag, " pre-edge R9"});
    @(posedge clk);
    if (wr_en && qualifies()) begin
      if (shape_sel) begin
        model[int'(wr_addr[4:0])]      = wr_data[0];
        model[32 + int'(wr_addr[4:0])] = wr_data[1];
      end else begin
        model[int'(wr_addr[5:0])] = wr_data[0];
      end
    end
    #1 check({tag, " post-edge R9"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; shape_sel = 1'b0; casc_cfg = 2'b00; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    model = '0;
    repeat (3) @(negedge clk);
    #1 check("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 64; a += 9) op(1'b0, 2'b00, 1'b0, 8'(a), 2'b11, 6'(a), "R1 after reset");

    // R2: deep write, data bit 1 ignored; R3 secondary zero
    op(1'b0, 2'b00, 1'b1, 8'd5, 2'b10, 6'd5, "R2 bit1 ignored");
    op(1'b0, 2'b00, 1'b1, 8'd5, 2'b01, 6'd5, "R2 write one");
    op(1'b0, 2'b00, 1'b0, 8'd0, 2'b00, 6'd5, "R3 read deep");

    // R4/R5: wide write with wr_addr[5] set, read with rd_addr[5] both ways
    op(1'b1, 2'b00, 1'b1, 8'b0010_0011, 2'b10, 6'd3, "R4 wide write");
    op(1'b1, 2'b00, 1'b0, 8'd0, 2'b00, 6'd35, "R5 upper read addr bit");

    // R6: reshape view of the same bits
    op(1'b0, 2'b00, 1'b0, 8'd0, 2'b00, 6'd3, "R6 deep low half");
    op(1'b0, 2'b00, 1'b0, 8'd0, 2'b00, 6'd35, "R6 deep high half");

    // R7: enable low
    op(1'b0, 2'b00, 1'b0, 8'd7, 2'b11, 6'd7, "R7 enable low");
    op(1'b1, 2'b00, 1'b0, 8'd7, 2'b11, 6'd7, "R7 enable low wide");

    // R8: cascade qualification
    op(1'b0, 2'b01, 1'b1, 8'b0100_1000, 2'b01, 6'd8, "R8 pair blocked");
    op(1'b0, 2'b01, 1'b1, 8'b1000_1001, 2'b01, 6'd9, "R8 pair allowed");
    op(1'b0, 2'b10, 1'b1, 8'b1000_1010, 2'b01, 6'd10, "R8 quad blocked");
    op(1'b0, 2'b10, 1'b1, 8'b0000_1010, 2'b01, 6'd10, "R8 quad allowed");
    op(1'b0, 2'b00, 1'b1, 8'b1100_1011, 2'b01, 6'd11, "R8 none ignores upper");
    op(1'b0, 2'b11, 1'b1, 8'b1100_1100, 2'b01, 6'd12, "R8 reserved ignores upper");

    // R9: write over a set bit at the read address
    op(1'b0, 2'b00, 1'b1, 8'd9, 2'b00, 6'd9, "R9 overwrite");

    // Mixed traffic across shapes and cascade settings
    for (int n = 0; n < 800; n++) begin
      logic [7:0] wa;
      logic [5:0] ra;
      logic sh;
      wa = 8'($urandom);
      ra = ($urandom % 3 == 0) ? wa[5:0] : 6'($urandom);
      sh = (n / 100) % 2 == 1;
      op(sh, 2'($urandom), 1'($urandom), wa, 2'($urandom), ra,
         sh ? "R4 R5 mixed" : "R2 R3 mixed");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule